// File: doc/BRIEF.md
# Prescaled 8-bit Pulse-Width Timer

This block produces a pulse-width modulated pair of outputs from the system clock. A programmable 8-bit divider makes a slow tick from the clock. Each tick advances an 8-bit count that runs from 0 to 254 and then wraps, so one repeat period always lasts 255 ticks. The primary output is high for the first part of each period. An on-time register sets how long that part is. The secondary output is either a true copy or an inverted copy of the primary.

A pending flag is set each period when the count moves past the on-time value. When its enable bit is set, the flag drives an interrupt request. In the alternate capture mode the outputs are held low and the same counter keeps running. On a chosen edge of a synchronised input, the current count is copied into a capture register and the pending flag is set. Writes to the control, on-time and divider registers come through simple write-enable ports. Every register can be read back on its own output.

Top module: `pwm_timer8`

## Requirements
- R1: The count advances once per prescaled tick through 0..254, and 254 is followed by 0, so a period lasts exactly 255 ticks.
- R2: The divider value D (0..255) produces one tick every D+1 clock cycles, so a period lasts 255*(D+1) clocks.
- R3: While running in PWM mode, `pwm_a` is 1 while the count is less than or equal to the active on-time value and 0 otherwise. An on-time of 255 keeps it at 1.
- R4: While running in PWM mode, `pwm_b` equals `pwm_a` when control bit 1 is 0, and equals its inverse when control bit 1 is 1.
- R5: While control bit 0 (run) is 0, the count and the divider are held at zero and both outputs are 0, whatever control bit 1 holds.
- R6: In PWM mode, control bit 3 (pending) becomes 1 in the cycle in which the count steps from the on-time value to that value plus one.
- R7: `irq` is 1 exactly when pending is 1 and control bit 2 (interrupt enable) is 1.
- R8: A control write with bit 3 = 0 clears pending. A write with bit 3 = 1 leaves pending unchanged. A set event in the same cycle as a clearing write leaves pending at 1.
- R9: A new on-time value is used only from the next wrap of the count to 0. While stopped, the written value is taken at once.
- R10: With control bit 5 = 1 (capture mode), both outputs are 0. An edge of `cap_in` copies the count into `cap_q` and sets pending. The edge is rising when control bit 4 = 1 and falling when it is 0. An edge of the other polarity changes neither `cap_q` nor pending.
- R11: Control bits 7:6 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data |
| ontime_we | input | 1 | Write strobe for the on-time register |
| ontime_wdata | input | 8 | On-time write data |
| div_we | input | 1 | Write strobe for the divider register |
| div_wdata | input | 8 | Divider write data |
| cap_in | input | 1 | Asynchronous capture input |
| ctrl_q | output | 8 | Control register readback |
| ontime_q | output | 8 | Written on-time value |
| div_q | output | 8 | Divider value |
| cnt_q | output | 8 | Current count |
| cap_q | output | 8 | Last captured count |
| pwm_a | output | 1 | Primary PWM output |
| pwm_b | output | 1 | Secondary PWM output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several things on every cycle. The count never leaves 0..254 and always wraps after 254. Pending only falls after a clearing write. The active on-time changes only at a wrap or while stopped. The outputs stay low when stopped and complementary when inversion is set. Other behaviour can only be shown by the bench scenarios. These cover the duty cycle measured across whole periods, the period length for several divider values, a reload written mid-period, the tie between setting and clearing pending, and the value captured for each edge polarity.

// File: rtl/pwm_timer8.sv
module pwm_timer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [7:0]   ctrl_wdata,
  input  logic         ontime_we,
  input  logic [W-1:0] ontime_wdata,
  input  logic         div_we,
  input  logic [7:0]   div_wdata,
  input  logic         cap_in,
  output logic [7:0]   ctrl_q,
  output logic [W-1:0] ontime_q,
  output logic [7:0]   div_q,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cap_q,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         irq
);
  localparam logic [W-1:0] LAST = {{(W-1){1'b1}}, 1'b0};

  logic run, inv_b, ien, pend, edge_rise, capm;
  logic [7:0]   pcnt, div_r;
  logic [W-1:0] cnt, on_sh, on_act, cap_r;
  logic cin_m, cin_s, cin_d;

  wire tick     = run && (pcnt == div_r);
  wire wrap     = tick && (cnt == LAST);
  wire edge_hit = edge_rise ? (cin_s & ~cin_d) : (~cin_s & cin_d);
  wire cap_ev   = run && capm && edge_hit;
  wire pass_ev  = run && !capm && tick && (cnt == on_act) && (cnt != LAST);
  wire set_ev   = pass_ev || cap_ev;
  wire clr_wr   = ctrl_we && !ctrl_wdata[3];
  wire on_phase = (cnt <= on_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; inv_b <= 1'b0; ien <= 1'b0; pend <= 1'b0;
      edge_rise <= 1'b0; capm <= 1'b0;
      pcnt <= '0; div_r <= '0; cnt <= '0; on_sh <= '0; on_act <= '0; cap_r <= '0;
      cin_m <= 1'b0; cin_s <= 1'b0; cin_d <= 1'b0;
    end else begin
      if (ctrl_we) begin
        run       <= ctrl_wdata[0];
        inv_b     <= ctrl_wdata[1];
        ien       <= ctrl_wdata[2];
        edge_rise <= ctrl_wdata[4];
        capm      <= ctrl_wdata[5];
      end
      pend <= set_ev || (pend && !clr_wr);
      if (div_we)    div_r <= div_wdata;
      if (ontime_we) on_sh <= ontime_wdata;
      if (!run || tick) pcnt <= '0;
      else              pcnt <= pcnt + 8'd1;
      if (!run)      cnt <= '0;
      else if (wrap) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
      if (!run || wrap) on_act <= on_sh;
      if (cap_ev) cap_r <= cnt;
      cin_m <= cap_in;
      cin_s <= cin_m;
      cin_d <= cin_s;
    end
  end

  assign ctrl_q   = {2'b00, capm, edge_rise, pend, ien, inv_b, run};
  assign ontime_q = on_sh;
  assign div_q    = div_r;
  assign cnt_q    = cnt;
  assign cap_q    = cap_r;
  assign pwm_a    = run && !capm && on_phase;
  assign pwm_b    = run && !capm && (on_phase ^ inv_b);
  assign irq      = pend && ien;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);                                                     // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt == LAST) |=> (cnt == '0));                    // R1
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (!pwm_a && !pwm_b));                               // R5
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !capm && inv_b) |-> (pwm_a != pwm_b));                    // R4
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(ctrl_we && !ctrl_wdata[3]));                // R8
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[3]);                                               // R7
  AST_RELOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(on_act) |-> $past(!run || (tick && cnt == LAST)));       // R9
endmodule

// File: tb/pwm_timer8_tb_top.sv
module pwm_timer8_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 0, ontime_we = 0, div_we = 0, cap_in = 0;
  logic [7:0] ctrl_wdata = 0, ontime_wdata = 0, div_wdata = 0;
  logic [7:0] ctrl_q, ontime_q, div_q, cnt_q, cap_q;
  logic pwm_a, pwm_b, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer8 dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ontime_we(ontime_we), .ontime_wdata(ontime_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .cap_in(cap_in),
    .ctrl_q(ctrl_q), .ontime_q(ontime_q), .div_q(div_q), .cnt_q(cnt_q),
    .cap_q(cap_q), .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_on(input logic [7:0] d);
    @(negedge clk); ontime_we = 1; ontime_wdata = d;
    @(negedge clk); ontime_we = 0;
  endtask
  task automatic wr_div(input logic [7:0] d);
    @(negedge clk); div_we = 1; div_wdata = d;
    @(negedge clk); div_we = 0;
  endtask
  task automatic wait_tick();
    logic [7:0] c0;
    c0 = cnt_q;
    while (cnt_q == c0) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ctrl_q == 8'h00, "R5 reset ctrl", ctrl_q, 0);
    chk(cnt_q == 0 && !pwm_a && !pwm_b && !irq, "R5 reset outputs", {pwm_a, pwm_b, irq}, 0);
  endtask

  task automatic t_stopped();
    wr_on(8'd100); wr_ctrl(8'h02);
    repeat (20) @(negedge clk);
    chk(cnt_q == 0, "R5 count held", cnt_q, 0);
    chk(!pwm_a && !pwm_b, "R5 outputs low with inversion", {pwm_a, pwm_b}, 0);
    wr_ctrl(8'hFC);
    chk(ctrl_q[7:6] == 2'b00, "R11 upper bits", ctrl_q[7:6], 0);
    wr_ctrl(8'h00);
  endtask

  task automatic t_duty(input logic [7:0] d, input logic [7:0] on);
    int hi = 0, exp;
    wr_ctrl(8'h00); wr_div(d); wr_on(on); wr_ctrl(8'h01);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 255 * (d + 1); i++) begin
      if (pwm_a) hi++;
      chk(pwm_b == pwm_a, "R4 true copy", pwm_b, pwm_a);
      @(negedge clk);
    end
    exp = (on == 8'd255) ? 255 * (d + 1) : (on + 1) * (d + 1);
    chk(hi == exp, "R3 high cycles per period", hi, exp);
  endtask

  task automatic t_period(input logic [7:0] d);
    int n = 0;
    wr_ctrl(8'h00); wr_div(d); wr_on(8'd40); wr_ctrl(8'h01);
    while (!(cnt_q == 0 && pwm_a)) @(negedge clk);
    while (cnt_q == 0) @(negedge clk);
    while (cnt_q != 0) begin n++; @(negedge clk); end
    chk(n + (d + 1) == 255 * (d + 1), "R1 R2 period length", n + d + 1, 255 * (d + 1));
  endtask

  task automatic t_invert();
    int bad = 0;
    wr_ctrl(8'h00); wr_div(8'd0); wr_on(8'd77); wr_ctrl(8'h03);
    for (int i = 0; i < 300; i++) begin
      if (pwm_b == pwm_a) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R4 inverted copy", bad, 0);
  endtask

  task automatic t_pending();
    wr_ctrl(8'h00); wr_div(8'd0); wr_on(8'd10); wr_ctrl(8'h01);
    while (cnt_q != 10) @(negedge clk);
    chk(!ctrl_q[3], "R6 not yet set", ctrl_q[3], 0);
    @(negedge clk);
    chk(ctrl_q[3] && cnt_q == 11, "R6 set on passing", {ctrl_q[3], cnt_q}, 11);
    chk(!irq, "R7 irq masked", irq, 0);
    while (cnt_q != 100) @(negedge clk);
    wr_ctrl(8'h0D);
    chk(ctrl_q[3] && irq, "R7 R8 write one keeps pending", {ctrl_q[3], irq}, 3);
    wr_ctrl(8'h05);
    chk(!ctrl_q[3] && !irq, "R8 write zero clears", {ctrl_q[3], irq}, 0);
    wr_ctrl(8'h0D);
    chk(!ctrl_q[3], "R8 write one no set", ctrl_q[3], 0);
    while (cnt_q != 10) @(negedge clk);
    ctrl_we = 1; ctrl_wdata = 8'h05;
    @(negedge clk); ctrl_we = 0;
    chk(ctrl_q[3] && irq, "R8 set beats clear", {ctrl_q[3], irq}, 3);
  endtask

  task automatic t_reload();
    int hi = 0, bad = 0;
    wr_ctrl(8'h00); wr_div(8'd0); wr_on(8'd50); wr_ctrl(8'h01);
    while (cnt_q != 100) @(negedge clk);
    wr_on(8'd200);
    while (cnt_q != 0) begin if (pwm_a) bad++; @(negedge clk); end
    chk(bad == 0, "R9 no glitch before wrap", bad, 0);
    for (int i = 0; i < 255; i++) begin if (pwm_a) hi++; @(negedge clk); end
    chk(hi == 201, "R9 new on-time after wrap", hi, 201);
  endtask

  task automatic t_capture();
    logic [7:0] a;
    cap_in = 0;
    wr_ctrl(8'h00); wr_div(8'd99); wr_ctrl(8'h31);
    repeat (600) @(negedge clk);
    chk(!pwm_a && !pwm_b, "R10 outputs low in capture", {pwm_a, pwm_b}, 0);
    wait_tick(); cap_in = 1; repeat (6) @(negedge clk);
    a = cnt_q;
    chk(cap_q == a && ctrl_q[3], "R10 rising capture", cap_q, a);
    wr_ctrl(8'h31);
    wait_tick(); cap_in = 0; repeat (6) @(negedge clk);
    chk(cap_q == a && !ctrl_q[3], "R10 falling ignored", cap_q, a);
    wr_ctrl(8'h21);
    wait_tick(); cap_in = 1; repeat (6) @(negedge clk);
    chk(cap_q == a && !ctrl_q[3], "R10 rising ignored", cap_q, a);
    wait_tick(); cap_in = 0; repeat (6) @(negedge clk);
    chk(cap_q == cnt_q && cap_q != a && ctrl_q[3], "R10 falling capture", cap_q, cnt_q);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_stopped();
    t_duty(8'd0, 8'd10);
    t_duty(8'd0, 8'd254);
    t_duty(8'd0, 8'd255);
    t_duty(8'd3, 8'd100);
    t_duty(8'd1, 8'd0);
    t_period(8'd0);
    t_period(8'd2);
    t_invert();
    t_pending();
    t_reload();
    t_capture();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule